// File: doc/BRIEF.md
# Sliding-Window Electromagnetic Cluster Finder

This block scans a small patch of calorimeter trigger towers for electromagnetic cluster candidates. Each clock it accepts a complete square grid of 8-bit tower energies, one grid for the electromagnetic layer and one for the hadronic layer. It evaluates every 4x4 tower window that fits inside the grid, stepping one tower at a time in both eta and phi. For every window it forms a cluster energy from the window's central 2x2 towers and two isolation energies from the twelve surrounding ring towers.

A window is declared a candidate only when its cluster energy is a local maximum against the eight windows that overlap it. A fixed tie-break makes a flat plateau of equal windows produce a single candidate. Each candidate is then compared against a bank of programmable threshold sets. Every set combines a minimum cluster energy with upper limits on the two isolation sums.

The result is a per-window candidate map and a pass map, together with a region-of-interest record for the first candidate found. The grid is expected to already include the border towers that the outermost windows need, so no data is exchanged with neighbouring logic.

Top module: `em_cluster_finder`

## Requirements
- R1: Tower (i, j), with i the eta row and j the phi column (both 0..6), sits at bits [(i*7+j)*8 +: 8] of `em_towers` and `had_towers`. Window position (p, q), with p and q in 0..3, covers rows p..p+3 and columns q..q+3. Its result bit in `cand_map` is p*4+q.
- R2: The cluster energy of a window is built from its central 2x2 block (rows p+1..p+2, columns q+1..q+2). It is the largest of the four adjacent electromagnetic pairs in that block (the two horizontal pairs and the two vertical pairs), plus the sum of the four hadronic towers of that block.
- R3: A window is a candidate when its cluster energy beats each of its eight overlapping neighbours. The comparison is strictly greater against neighbours one row lower in eta, or in the same row one column lower in phi, and greater-or-equal against all other neighbours. Neighbours one step outside the 4x4 position array take part, and their central blocks still lie inside the grid. As a result, an isolated tower whose four windows tie yields one candidate at the lowest of those positions.
- R4: The electromagnetic isolation of a window is the sum of its 12 electromagnetic towers outside the central 2x2 block. The hadronic isolation is the same sum taken over the hadronic layer.
- R5: Threshold set k passes for a window when three conditions hold: the window is a candidate, its cluster energy is strictly greater than the set's cluster threshold, and each isolation sum is at or below the set's matching limit. The result is bit (p*4+q)*8+k of `pass_map`. Non-candidates have all eight bits clear.
- R6: When `cfg_we` is high at a rising clock edge, set `cfg_sel` takes `cfg_clus_thr`, `cfg_em_iso` and `cfg_had_iso`. When `cfg_we` is low, no threshold changes.
- R7: `roi_hit` is high when any window is a candidate. `roi_eta`, `roi_phi` and `roi_pass` then give p, q and the eight pass bits of the candidate with the lowest index p*4+q.
- R8: A new grid may be presented on every clock. Results for a grid presented with `in_valid` high appear three rising edges later, with `out_valid` high. A grid presented with `in_valid` low produces `out_valid` low.
- R9: Reset clears `out_valid`, `cand_map` and `roi_hit`, and sets every threshold and isolation limit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Grid on the tower inputs is valid |
| em_towers | input | 392 | Electromagnetic tower grid, 7x7 by 8 bits |
| had_towers | input | 392 | Hadronic tower grid, 7x7 by 8 bits |
| cfg_we | input | 1 | Threshold write enable |
| cfg_sel | input | 3 | Threshold set to write |
| cfg_clus_thr | input | 11 | Cluster energy threshold |
| cfg_em_iso | input | 12 | Electromagnetic isolation limit |
| cfg_had_iso | input | 12 | Hadronic isolation limit |
| out_valid | output | 1 | Results below are valid |
| cand_map | output | 16 | Candidate flag per window position |
| pass_map | output | 128 | Threshold pass bits per window position |
| roi_hit | output | 1 | At least one candidate present |
| roi_eta | output | 2 | Eta position of the first candidate |
| roi_phi | output | 2 | Phi position of the first candidate |
| roi_pass | output | 8 | Pass bitmap of the first candidate |

## Verification
The bench builds the block with its default parameters: 8-bit towers, a 7x7 grid and eight threshold sets. With these values the 4x4 position array has windows on all four edges, so the extended neighbour ring of R3 is exercised. The eight sets are enough to place each isolation limit and the cluster threshold exactly on, and one step off, their boundary at the same time. Back-to-back and gapped random grids test the three-cycle pipeline and the lowest-index record selection when several candidates share one grid.

// File: rtl/em_cf_pkg.sv
package em_cf_pkg;
   // Window edge length in towers; the cluster core is the central 2x2.
   localparam int WIN = 4;

   // True for the central 2x2 block of a 4x4 window (row/col offsets).
   function automatic logic in_core(input int r, input int c);
      return (r >= 1) && (r <= 2) && (c >= 1) && (c <= 2);
   endfunction

   // Neighbour offsets that must be strictly beaten (tie-break side).
   function automatic logic is_earlier(input int de, input int dp);
      return (de < 0) || ((de == 0) && (dp < 0));
   endfunction
endpackage

// File: rtl/cf_window_sums.sv
module cf_window_sums
   import em_cf_pkg::*;
#(
   parameter int TOWER_W = 8,
   parameter int GRID    = 7
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic [GRID*GRID*TOWER_W-1:0]                em_i,
   input  logic [GRID*GRID*TOWER_W-1:0]                had_i,
   output logic [(GRID-WIN+3)*(GRID-WIN+3)*(TOWER_W+3)-1:0] clus_q,
   output logic [(GRID-WIN+1)*(GRID-WIN+1)*(TOWER_W+4)-1:0] emiso_q,
   output logic [(GRID-WIN+1)*(GRID-WIN+1)*(TOWER_W+4)-1:0] hadiso_q
);
   localparam int NPOS   = GRID - WIN + 1;
   localparam int NEXT   = NPOS + 2;
   localparam int NWIN   = NPOS * NPOS;
   localparam int CLUS_W = TOWER_W + 3;
   localparam int ISO_W  = TOWER_W + 4;

   function automatic logic [TOWER_W-1:0] tw(input logic [GRID*GRID*TOWER_W-1:0] g,
                                             input int r, input int c);
      return g[(r*GRID+c)*TOWER_W +: TOWER_W];
   endfunction

   logic [NEXT*NEXT*CLUS_W-1:0] clus_d;
   logic [NWIN*ISO_W-1:0]       emiso_d;
   logic [NWIN*ISO_W-1:0]       hadiso_d;

   // R2: cluster energy for the extended (NPOS+2)^2 array; index e covers core rows e..e+1
   for (genvar e = 0; e < NEXT; e++) begin : g_ce
      for (genvar f = 0; f < NEXT; f++) begin : g_cf
         logic [TOWER_W:0]   s_top, s_bot, s_lft, s_rgt, s_row, s_col, s_best;
         logic [TOWER_W+1:0] s_had;
         assign s_top  = {1'b0, tw(em_i, e, f)}     + {1'b0, tw(em_i, e, f+1)};
         assign s_bot  = {1'b0, tw(em_i, e+1, f)}   + {1'b0, tw(em_i, e+1, f+1)};
         assign s_lft  = {1'b0, tw(em_i, e, f)}     + {1'b0, tw(em_i, e+1, f)};
         assign s_rgt  = {1'b0, tw(em_i, e, f+1)}   + {1'b0, tw(em_i, e+1, f+1)};
         assign s_row  = (s_top > s_bot) ? s_top : s_bot;
         assign s_col  = (s_lft > s_rgt) ? s_lft : s_rgt;
         assign s_best = (s_row > s_col) ? s_row : s_col;
         assign s_had  = {2'b0, tw(had_i, e, f)}   + {2'b0, tw(had_i, e, f+1)}
                       + {2'b0, tw(had_i, e+1, f)} + {2'b0, tw(had_i, e+1, f+1)};
         assign clus_d[(e*NEXT+f)*CLUS_W +: CLUS_W] = CLUS_W'(s_best) + CLUS_W'(s_had);
      end
   end

   // R4: ring sums of the 12 non-core towers, per layer
   for (genvar p = 0; p < NPOS; p++) begin : g_ip
      for (genvar q = 0; q < NPOS; q++) begin : g_iq
         logic [ISO_W-1:0] ring_em, ring_had;
         always_comb begin
            ring_em  = '0;
            ring_had = '0;
            for (int r = 0; r < WIN; r++) begin
               for (int c = 0; c < WIN; c++) begin
                  if (!in_core(r, c)) begin
                     ring_em  = ring_em  + ISO_W'(tw(em_i,  p+r, q+c));
                     ring_had = ring_had + ISO_W'(tw(had_i, p+r, q+c));
                  end
               end
            end
         end
         assign emiso_d[(p*NPOS+q)*ISO_W +: ISO_W]  = ring_em;
         assign hadiso_d[(p*NPOS+q)*ISO_W +: ISO_W] = ring_had;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clus_q   <= '0;
         emiso_q  <= '0;
         hadiso_q <= '0;
      end else begin
         clus_q   <= clus_d;
         emiso_q  <= emiso_d;
         hadiso_q <= hadiso_d;
      end
   end
endmodule

// File: rtl/cf_thr_bank.sv
module cf_thr_bank #(
   parameter int NSET   = 8,
   parameter int CLUS_W = 11,
   parameter int ISO_W  = 12,
   parameter int SEL_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [SEL_W-1:0]         cfg_sel,
   input  logic [CLUS_W-1:0]        cfg_clus_thr,
   input  logic [ISO_W-1:0]         cfg_em_iso,
   input  logic [ISO_W-1:0]         cfg_had_iso,
   output logic [NSET*CLUS_W-1:0]   thr_clus_o,
   output logic [NSET*ISO_W-1:0]    thr_em_o,
   output logic [NSET*ISO_W-1:0]    thr_had_o
);
   logic [CLUS_W-1:0] clus_r [NSET];
   logic [ISO_W-1:0]  em_r   [NSET];
   logic [ISO_W-1:0]  had_r  [NSET];

   // R6, R9: addressed write, zero on reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NSET; k++) begin
            clus_r[k] <= '0;
            em_r[k]   <= '0;
            had_r[k]  <= '0;
         end
      end else if (cfg_we) begin
         for (int k = 0; k < NSET; k++) begin
            if (int'(cfg_sel) == k) begin
               clus_r[k] <= cfg_clus_thr;
               em_r[k]   <= cfg_em_iso;
               had_r[k]  <= cfg_had_iso;
            end
         end
      end
   end

   for (genvar k = 0; k < NSET; k++) begin : g_out
      assign thr_clus_o[k*CLUS_W +: CLUS_W] = clus_r[k];
      assign thr_em_o[k*ISO_W +: ISO_W]     = em_r[k];
      assign thr_had_o[k*ISO_W +: ISO_W]    = had_r[k];
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> ($stable(thr_clus_o) && $stable(thr_em_o) && $stable(thr_had_o)))
      else $error("threshold bank changed without a write"); // R6
endmodule

// File: rtl/cf_decide.sv
module cf_decide
   import em_cf_pkg::*;
#(
   parameter int NPOS   = 4,
   parameter int NSET   = 8,
   parameter int CLUS_W = 11,
   parameter int ISO_W  = 12
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [(NPOS+2)*(NPOS+2)*CLUS_W-1:0]    clus_i,
   input  logic [NPOS*NPOS*ISO_W-1:0]             emiso_i,
   input  logic [NPOS*NPOS*ISO_W-1:0]             hadiso_i,
   input  logic [NSET*CLUS_W-1:0]                 thr_clus_i,
   input  logic [NSET*ISO_W-1:0]                  thr_em_i,
   input  logic [NSET*ISO_W-1:0]                  thr_had_i,
   output logic [NPOS*NPOS-1:0]                   cand_q,
   output logic [NPOS*NPOS*NSET-1:0]              pass_q
);
   localparam int NEXT = NPOS + 2;
   localparam int NWIN = NPOS * NPOS;

   logic [NWIN-1:0]      cand_d;
   logic [NWIN*NSET-1:0] pass_d;

   for (genvar p = 0; p < NPOS; p++) begin : g_dp
      for (genvar q = 0; q < NPOS; q++) begin : g_dq
         localparam int E   = p + 1;
         localparam int F   = q + 1;
         localparam int IDX = p*NPOS + q;
         logic [CLUS_W-1:0] own;
         logic [ISO_W-1:0]  iso_e, iso_h;
         logic              peak;

         assign own   = clus_i[(E*NEXT+F)*CLUS_W +: CLUS_W];
         assign iso_e = emiso_i[IDX*ISO_W +: ISO_W];
         assign iso_h = hadiso_i[IDX*ISO_W +: ISO_W];

         // R3: local maximum with asymmetric tie-break
         always_comb begin
            peak = 1'b1;
            for (int de = -1; de <= 1; de++) begin
               for (int dp = -1; dp <= 1; dp++) begin
                  if ((de != 0) || (dp != 0)) begin
                     if (is_earlier(de, dp))
                        peak = peak & (own >  clus_i[((E+de)*NEXT+(F+dp))*CLUS_W +: CLUS_W]);
                     else
                        peak = peak & (own >= clus_i[((E+de)*NEXT+(F+dp))*CLUS_W +: CLUS_W]);
                  end
               end
            end
         end
         assign cand_d[IDX] = peak;

         // R5: each set joins a cluster minimum with two isolation ceilings
         for (genvar k = 0; k < NSET; k++) begin : g_set
            assign pass_d[IDX*NSET+k] = peak
               && (own   >  thr_clus_i[k*CLUS_W +: CLUS_W])
               && (iso_e <= thr_em_i[k*ISO_W +: ISO_W])
               && (iso_h <= thr_had_i[k*ISO_W +: ISO_W]);
         end

         if (q < NPOS-1) begin : g_chk_phi
            AST_NO_TWIN_PHI: assert property (@(posedge clk) disable iff (!rst_n)
               !(cand_q[IDX] && cand_q[IDX+1]))
               else $error("adjacent phi candidates"); // R3
         end
         if (p < NPOS-1) begin : g_chk_eta
            AST_NO_TWIN_ETA: assert property (@(posedge clk) disable iff (!rst_n)
               !(cand_q[IDX] && cand_q[IDX+NPOS]))
               else $error("adjacent eta candidates"); // R3
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= '0;
         pass_q <= '0;
      end else begin
         cand_q <= cand_d;
         pass_q <= pass_d;
      end
   end
endmodule

// File: rtl/em_cluster_finder.sv
module em_cluster_finder
   import em_cf_pkg::*;
#(
   parameter int TOWER_W = 8,
   parameter int GRID    = 7,
   parameter int NSET    = 8,
   localparam int NPOS   = GRID - WIN + 1,
   localparam int NWIN   = NPOS * NPOS,
   localparam int CLUS_W = TOWER_W + 3,
   localparam int ISO_W  = TOWER_W + 4,
   localparam int SEL_W  = (NSET > 1) ? $clog2(NSET) : 1,
   localparam int POS_W  = (NPOS > 1) ? $clog2(NPOS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [GRID*GRID*TOWER_W-1:0] em_towers,
   input  logic [GRID*GRID*TOWER_W-1:0] had_towers,
   input  logic                         cfg_we,
   input  logic [SEL_W-1:0]             cfg_sel,
   input  logic [CLUS_W-1:0]            cfg_clus_thr,
   input  logic [ISO_W-1:0]             cfg_em_iso,
   input  logic [ISO_W-1:0]             cfg_had_iso,
   output logic                         out_valid,
   output logic [NWIN-1:0]              cand_map,
   output logic [NWIN*NSET-1:0]         pass_map,
   output logic                         roi_hit,
   output logic [POS_W-1:0]             roi_eta,
   output logic [POS_W-1:0]             roi_phi,
   output logic [NSET-1:0]              roi_pass
);
   localparam int NEXT  = NPOS + 2;
   localparam int IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1;

   // Elaboration-time parameter checks
   if (GRID < WIN) begin : g_bad_grid
      $error("GRID must be at least the window size");
   end
   if (TOWER_W < 1) begin : g_bad_tw
      $error("TOWER_W must be positive");
   end
   if (NSET < 1) begin : g_bad_nset
      $error("NSET must be positive");
   end

   logic [NEXT*NEXT*CLUS_W-1:0] clus_s1;
   logic [NWIN*ISO_W-1:0]       emiso_s1, hadiso_s1;
   logic [NSET*CLUS_W-1:0]      thr_clus;
   logic [NSET*ISO_W-1:0]       thr_em, thr_had;
   logic [NWIN-1:0]             cand_s2;
   logic [NWIN*NSET-1:0]        pass_s2;
   logic                        v_s1, v_s2;

   cf_window_sums #(.TOWER_W(TOWER_W), .GRID(GRID)) u_sums (
      .clk(clk), .rst_n(rst_n), .em_i(em_towers), .had_i(had_towers),
      .clus_q(clus_s1), .emiso_q(emiso_s1), .hadiso_q(hadiso_s1));

   cf_thr_bank #(.NSET(NSET), .CLUS_W(CLUS_W), .ISO_W(ISO_W), .SEL_W(SEL_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_clus_thr(cfg_clus_thr), .cfg_em_iso(cfg_em_iso), .cfg_had_iso(cfg_had_iso),
      .thr_clus_o(thr_clus), .thr_em_o(thr_em), .thr_had_o(thr_had));

   cf_decide #(.NPOS(NPOS), .NSET(NSET), .CLUS_W(CLUS_W), .ISO_W(ISO_W)) u_decide (
      .clk(clk), .rst_n(rst_n), .clus_i(clus_s1), .emiso_i(emiso_s1), .hadiso_i(hadiso_s1),
      .thr_clus_i(thr_clus), .thr_em_i(thr_em), .thr_had_i(thr_had),
      .cand_q(cand_s2), .pass_q(pass_s2));

   // R7: lowest-index candidate selection
   logic [IDX_W-1:0] first_idx;
   logic             any_cand;
   always_comb begin
      first_idx = '0;
      any_cand  = |cand_s2;
      for (int i = NWIN-1; i >= 0; i--) begin
         if (cand_s2[i]) first_idx = IDX_W'(i);
      end
   end

   // R8, R9: valid pipeline and output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_s1      <= 1'b0;
         v_s2      <= 1'b0;
         out_valid <= 1'b0;
         cand_map  <= '0;
         pass_map  <= '0;
         roi_hit   <= 1'b0;
         roi_eta   <= '0;
         roi_phi   <= '0;
         roi_pass  <= '0;
      end else begin
         v_s1      <= in_valid;
         v_s2      <= v_s1;
         out_valid <= v_s2;
         cand_map  <= cand_s2;
         pass_map  <= pass_s2;
         roi_hit   <= any_cand;
         roi_eta   <= POS_W'(int'(first_idx) / NPOS);
         roi_phi   <= POS_W'(int'(first_idx) % NPOS);
         roi_pass  <= pass_s2[first_idx*NSET +: NSET];
      end
   end

   // Checks on the output record
   int            chk_idx;
   logic [NWIN-1:0] chk_below;
   assign chk_idx   = int'(roi_eta) * NPOS + int'(roi_phi);
   assign chk_below = (NWIN'(1) << chk_idx) - NWIN'(1);

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid, 3))
      else $error("valid latency broken"); // R8
   AST_ROI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && roi_hit) |-> (cand_map[chk_idx] && ((cand_map & chk_below) == '0)))
      else $error("record is not the first candidate"); // R7
   AST_ROI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !roi_hit) |-> (cand_map == '0))
      else $error("hit flag low with candidates present"); // R7
   AST_ROI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && roi_hit) |-> (roi_pass == pass_map[chk_idx*NSET +: NSET]))
      else $error("record pass bits mismatch"); // R7
endmodule

// File: tb/sim_em_cluster_finder.sv
`timescale 1ns/1ps
module sim_em_cluster_finder;
   localparam int G = 7;
   localparam int NP = 4;
   localparam int NS = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [G*G*8-1:0] em_towers = '0;
   logic [G*G*8-1:0] had_towers = '0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [10:0] cfg_clus_thr = '0;
   logic [11:0] cfg_em_iso = '0;
   logic [11:0] cfg_had_iso = '0;
   logic out_valid;
   logic [15:0] cand_map;
   logic [127:0] pass_map;
   logic roi_hit;
   logic [1:0] roi_eta, roi_phi;
   logic [7:0] roi_pass;

   em_cluster_finder u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .em_towers(em_towers), .had_towers(had_towers),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_clus_thr(cfg_clus_thr),
      .cfg_em_iso(cfg_em_iso), .cfg_had_iso(cfg_had_iso),
      .out_valid(out_valid), .cand_map(cand_map), .pass_map(pass_map),
      .roi_hit(roi_hit), .roi_eta(roi_eta), .roi_phi(roi_phi), .roi_pass(roi_pass));

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   int em_a [G][G];
   int had_a [G][G];
   int tc [NS];
   int te [NS];
   int th [NS];

   bit           exp_v    [64];
   logic [15:0]  exp_cand [64];
   logic [127:0] exp_pass [64];
   bit           exp_hit  [64];
   int           exp_eta  [64];
   int           exp_phi  [64];
   logic [7:0]   exp_rp   [64];

   int         lit_mode = 0;
   logic [7:0] lit_pass = '0;

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(4 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Model of R2: cluster energy of an extended window with core rows e..e+1
   function automatic int clus_ext(input int e, input int f);
      int a, b, c, d, m;
      a = em_a[e][f]; b = em_a[e][f+1]; c = em_a[e+1][f]; d = em_a[e+1][f+1];
      m = a + b;
      if (c + d > m) m = c + d;
      if (a + c > m) m = a + c;
      if (b + d > m) m = b + d;
      return m + had_a[e][f] + had_a[e][f+1] + had_a[e+1][f] + had_a[e+1][f+1];
   endfunction

   // Model of R4
   function automatic int ring_sum(input bit had, input int p, input int q);
      int s = 0;
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++)
            if (!((r == 1 || r == 2) && (c == 1 || c == 2)))
               s += had ? had_a[p+r][q+c] : em_a[p+r][q+c];
      return s;
   endfunction

   // Model of R3
   function automatic bit is_cand(input int p, input int q);
      int own = clus_ext(p+1, q+1);
      bit ok = 1;
      for (int de = -1; de <= 1; de++)
         for (int dp = -1; dp <= 1; dp++) begin
            if (de == 0 && dp == 0) continue;
            if (de < 0 || (de == 0 && dp < 0)) begin
               if (!(own > clus_ext(p+1+de, q+1+dp))) ok = 0;
            end else begin
               if (!(own >= clus_ext(p+1+de, q+1+dp))) ok = 0;
            end
         end
      return ok;
   endfunction

   task automatic model(input int k);
      bit found = 0;
      exp_cand[k] = '0; exp_pass[k] = '0; exp_hit[k] = 0;
      exp_eta[k] = 0; exp_phi[k] = 0; exp_rp[k] = '0;
      for (int p = 0; p < NP; p++)
         for (int q = 0; q < NP; q++) begin
            bit c = is_cand(p, q);
            int cl = clus_ext(p+1, q+1);
            int ie = ring_sum(0, p, q);
            int ih = ring_sum(1, p, q);
            logic [7:0] pb = '0;
            for (int s = 0; s < NS; s++)
               pb[s] = c && (cl > tc[s]) && (ie <= te[s]) && (ih <= th[s]);
            exp_cand[k][p*NP+q] = c;
            exp_pass[k][(p*NP+q)*NS +: NS] = pb;
            if (c && !found) begin
               found = 1; exp_hit[k] = 1; exp_eta[k] = p; exp_phi[k] = q; exp_rp[k] = pb;
            end
         end
   endtask

   task automatic drive_grid();
      for (int i = 0; i < G; i++)
         for (int j = 0; j < G; j++) begin
            em_towers[(i*G+j)*8 +: 8]  = 8'(em_a[i][j]);
            had_towers[(i*G+j)*8 +: 8] = 8'(had_a[i][j]);
         end
   endtask

   task automatic make_grid(input int kind);
      for (int i = 0; i < G; i++)
         for (int j = 0; j < G; j++) begin
            em_a[i][j] = 0; had_a[i][j] = 0;
         end
      case (kind)
         1: em_a[3][3] = 200;
         2: begin
            for (int i = 0; i < G; i++)
               for (int j = 0; j < G; j++) begin
                  em_a[i][j]  = $urandom_range(0, 12);
                  had_a[i][j] = $urandom_range(0, 6);
               end
            for (int n = 0; n < 3; n++) begin
               em_a[$urandom_range(0, G-1)][$urandom_range(0, G-1)] = $urandom_range(60, 255);
               if ($urandom_range(0, 1) == 1)
                  had_a[$urandom_range(0, G-1)][$urandom_range(0, G-1)] = $urandom_range(20, 120);
            end
         end
         3: begin
            em_a[3][3]  = 200;
            em_a[1][1]  = 30;
            had_a[1][4] = 20;
         end
         default: ;
      endcase
   endtask

   task automatic check_slot(input int s);
      chk("R8 out_valid", 128'(out_valid), 128'(exp_v[s]));
      if (exp_v[s]) begin
         chk("R1/R2/R3 cand_map", 128'(cand_map), 128'(exp_cand[s]));
         chk("R2/R4/R5 pass_map", pass_map, exp_pass[s]);
         chk("R7 roi_hit", 128'(roi_hit), 128'(exp_hit[s]));
         if (exp_hit[s]) begin
            chk("R7 roi_eta", 128'(roi_eta), 128'(exp_eta[s]));
            chk("R7 roi_phi", 128'(roi_phi), 128'(exp_phi[s]));
            chk("R7 roi_pass", 128'(roi_pass), 128'(exp_rp[s]));
         end
         if (lit_mode != 0) begin
            chk("R3 plateau single candidate", 128'(cand_map), 128'(16'h0020));
            chk("R7 plateau record eta", 128'(roi_eta), 128'd1);
            chk("R7 plateau record phi", 128'(roi_phi), 128'd1);
            chk("R5/R6/R9 literal pass bits", 128'(roi_pass), 128'(lit_pass));
         end
      end
   endtask

   task automatic run_batch(input int n, input int kind, input bit gaps);
      for (int k = 0; k < n + 3; k++) begin
         @(negedge clk);
         if (k >= 3) check_slot(k - 3);
         if (k < n) begin
            make_grid(kind);
            drive_grid();
            if (gaps && (k % 2 == 1)) begin
               exp_v[k] = 0;
               in_valid = 1'b0;
            end else begin
               model(k);
               exp_v[k] = 1;
               in_valid = 1'b1;
            end
         end else begin
            in_valid = 1'b0;
         end
      end
   endtask

   task automatic wr_cfg(input int sel, input int c, input int e, input int h, input bit we);
      @(negedge clk);
      cfg_sel = 3'(sel); cfg_clus_thr = 11'(c); cfg_em_iso = 12'(e); cfg_had_iso = 12'(h);
      cfg_we = we;
      if (we) begin
         tc[sel] = c; te[sel] = e; th[sel] = h;
      end
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin : main
      int seed_init;
      seed_init = $urandom(32'd51807);
      for (int s = 0; s < NS; s++) begin
         tc[s] = 0; te[s] = 0; th[s] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 out_valid after reset", 128'(out_valid), 128'd0);
      chk("R9 cand_map after reset", 128'(cand_map), 128'd0);
      chk("R9 roi_hit after reset", 128'(roi_hit), 128'd0);

      // R3 plateau with R9 zero thresholds: every set passes
      lit_mode = 1; lit_pass = 8'hFF;
      run_batch(1, 1, 0);

      // R5 boundaries, R6 ignored write
      wr_cfg(0, 199, 30, 20, 1);
      wr_cfg(1, 200, 300, 300, 1);
      wr_cfg(2, 0, 29, 300, 1);
      wr_cfg(3, 0, 300, 19, 1);
      wr_cfg(4, 0, 255, 255, 1);
      for (int s = 5; s < NS; s++) wr_cfg(s, 2047, 4095, 4095, 1);
      wr_cfg(1, 0, 4095, 4095, 0);
      lit_mode = 1; lit_pass = 8'h11;
      run_batch(1, 3, 0);
      lit_mode = 0;

      // Empty grid: no candidate
      run_batch(2, 0, 0);

      // Random thresholds, back-to-back and gapped random grids
      for (int s = 0; s < NS; s++)
         wr_cfg(s, $urandom_range(0, 700), $urandom_range(0, 300), $urandom_range(0, 150), 1);
      run_batch(60, 2, 0);
      run_batch(40, 2, 1);
      for (int s = 0; s < NS; s++)
         wr_cfg(s, $urandom_range(100, 400), $urandom_range(20, 120), $urandom_range(0, 60), 1);
      run_batch(60, 2, 0);

      @(negedge clk);
      chk("R8 out_valid idle", 128'(out_valid), 128'd0);
      finish_run();
   end
endmodule